// File: doc/BRIEF.md
# Protection Region Configuration Registers

This block holds the programmable state of a bank of memory-protection entries on a 32-bit machine. There are sixteen entries by default. Each entry has an 8-bit configuration byte and a 32-bit address word. One small security register sits beside them. Software reaches all of this through a single register port made of a select, an index, write data and a write strobe. The read data comes back combinationally for the selected register.

Every write passes through acceptance rules before it lands. The rules depend on these things:
- the target entry's lock bit;
- a lock held by the following entry when that entry uses top-of-range matching;
- an enhanced-mode input;
- three security flags: lockdown, whitelist policy and rule-lock bypass.

All configuration bytes, address words and security flags are exported flat to the region decoder and access checker downstream. A one-cycle change pulse tells those consumers that a configuration byte or an address word has been updated.

Top module: `prot_region_regs`

## Requirements
- R1: Configuration byte fields are: read at bit 0, write at bit 1, execute at bit 2, match mode at bits 4:3 (0 = off, 1 = top-of-range), lock at bit 7. Byte lane i (bits 8i+7:8i) of configuration register n (select 0) maps to entry 4n+i. A read of that register returns the same four bytes. Entry k's byte appears on `cfg_flat[8k+7:8k]`, and its address word on `addr_flat[32k+31:32k]`.
- R2: After reset, every configuration byte, address word and security flag reads as 0, and `cfg_changed` is low.
- R3: With `enhanced_en` low, a configuration byte write is dropped when that entry's lock bit is set. The other bytes of the same register write still take effect.
- R4: With `enhanced_en` high and the bypass flag set, every configuration byte write is taken, even into a locked entry.
- R5: With `enhanced_en` high, bypass clear and lockdown set, a configuration byte is taken only in two cases: the new byte has lock=1 and execute=0, or the new byte has lock=0 and its low three bits are not exactly write+execute (110b). The current lock state plays no part.
- R6: With `enhanced_en` high and both bypass and lockdown clear, a locked entry's configuration byte is kept, as in R3.
- R7: An address word write (select 1) is dropped when the entry's own lock bit is set.
- R8: An address word write to entry k is dropped when entry k+1 has lock=1 and match mode 1. The last entry has no such neighbour check, and a locked neighbour in mode 0 does not block.
- R9: The security register (select 2) holds lockdown at bit 0, whitelist policy at bit 1 and bypass at bit 2. Once set, lockdown and whitelist stay set on every later write.
- R10: Bypass cannot change from 0 to 1 while any entry has its lock bit set. Setting it with no locks is allowed, and clearing it is always allowed.
- R11: Writes to a configuration index of 4 or more, or to an address index of 16 or more, change nothing. Reads of such indices, and of select 3, return 0.
- R12: `cfg_changed` is high for exactly the cycle after an accepted configuration or address write. A configuration write counts as accepted when at least one of its bytes was taken. Rejected writes, out-of-range writes and security writes produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enhanced_en | input | 1 | Enables the security-flag dependent write rules |
| csr_sel | input | 2 | 0 config, 1 address, 2 security, 3 none |
| csr_idx | input | 6 | Register index within the selected group |
| csr_wdata | input | 32 | Write data |
| csr_we | input | 1 | Write strobe, one write per cycle |
| csr_rdata | output | 32 | Combinational read data for sel/idx |
| cfg_flat | output | 128 | All configuration bytes, entry k at bits 8k+7:8k |
| addr_flat | output | 512 | All address words, entry k at bits 32k+31:32k |
| sec_lockdown | output | 1 | Lockdown flag |
| sec_whitelist | output | 1 | Whitelist-policy flag |
| sec_bypass | output | 1 | Rule-lock bypass flag |
| cfg_changed | output | 1 | One-cycle pulse after an accepted config or address write |

## Verification
Some states are hard to reach from the ports. Locks cannot be removed by writes in the basic mode, so reaching a clean state for the enhanced-mode tests requires a mid-run reset. Bypass can be raised only before the first lock is written, so the stimulus raises it first and then tests locked entries under bypass. The lockdown cases are driven with one register write whose four byte lanes each hit a different row of the acceptance rule. That single write both exercises R5 and yields a partially accepted write that must still pulse.

// File: rtl/prr_pkg.sv
package prr_pkg;

  localparam int CFG_W  = 8;
  localparam int BIT_R  = 0;
  localparam int BIT_W  = 1;
  localparam int BIT_X  = 2;
  localparam int BIT_L  = 7;

  localparam int SEC_LOCKDOWN  = 0;
  localparam int SEC_WHITELIST = 1;
  localparam int SEC_BYPASS    = 2;
  localparam int SEC_W         = 3;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_SEC  = 2'd2,
    SEL_NONE = 2'd3
  } csr_sel_e;

  function automatic match_mode_e cfg_mode(logic [CFG_W-1:0] c);
    return match_mode_e'(c[4:3]);
  endfunction

  // Acceptance of one configuration byte
  function automatic logic cfg_write_ok(logic enh, logic byp, logic lockdown,
                                        logic [CFG_W-1:0] cur,
                                        logic [CFG_W-1:0] nxt);
    logic wx_only;
    logic ok;
    wx_only = nxt[BIT_W] && nxt[BIT_X] && !nxt[BIT_R];
    if (!enh)          ok = !cur[BIT_L];
    else if (byp)      ok = 1'b1;
    else if (lockdown) ok = (nxt[BIT_L] && !nxt[BIT_X]) ||
                            (!nxt[BIT_L] && !wx_only);
    else               ok = !cur[BIT_L];
    return ok;
  endfunction

  // Acceptance of one address word
  function automatic logic addr_write_ok(logic [CFG_W-1:0] own,
                                         logic has_next,
                                         logic [CFG_W-1:0] nxt);
    logic nxt_blocks;
    nxt_blocks = has_next && nxt[BIT_L] && (cfg_mode(nxt) == MATCH_TOR);
    return !own[BIT_L] && !nxt_blocks;
  endfunction

  // Next value of the security flags on a write
  function automatic logic [SEC_W-1:0] sec_update(logic [SEC_W-1:0] cur,
                                                  logic [SEC_W-1:0] wr,
                                                  logic any_locked);
    logic [SEC_W-1:0] n;
    n[SEC_LOCKDOWN]  = cur[SEC_LOCKDOWN]  | wr[SEC_LOCKDOWN];
    n[SEC_WHITELIST] = cur[SEC_WHITELIST] | wr[SEC_WHITELIST];
    n[SEC_BYPASS]    = wr[SEC_BYPASS] & (cur[SEC_BYPASS] | !any_locked);
    return n;
  endfunction

endpackage

// File: rtl/prr_cfg_bank.sv
module prr_cfg_bank
  import prr_pkg::*;
#(
  parameter int N     = 16,
  parameter int XLEN  = 32,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              enhanced_en,
  input  logic              sec_bypass,
  input  logic              sec_lockdown,
  output logic [N*CFG_W-1:0] cfg_flat,
  output logic              accept_any,
  output logic              any_locked
);

  localparam int BYTES = XLEN / CFG_W;

  logic [CFG_W-1:0] cfg_r [N];
  logic [N-1:0]     acc;

  for (genvar k = 0; k < N; k++) begin : g_ent
    localparam int CSR_NUM = k / BYTES;
    localparam int LANE    = k % BYTES;
    logic [CFG_W-1:0] new_byte;
    logic             hit;

    assign new_byte = wr_data[LANE*CFG_W +: CFG_W];
    assign hit      = wr_en && (wr_idx == IDX_W'(CSR_NUM));
    assign acc[k]   = hit && cfg_write_ok(enhanced_en, sec_bypass, sec_lockdown,
                                          cfg_r[k], new_byte);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_r[k] <= '0;
      else if (acc[k]) cfg_r[k] <= new_byte;
    end

    assign cfg_flat[k*CFG_W +: CFG_W] = cfg_r[k];

    AST_CFG_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!enhanced_en && cfg_r[k][BIT_L]) |=> (cfg_r[k] == $past(cfg_r[k]))); // R3
  end

  assign accept_any = |acc;

  always_comb begin
    any_locked = 1'b0;
    for (int k = 0; k < N; k++) any_locked = any_locked | cfg_r[k][BIT_L];
  end

endmodule

// File: rtl/prr_addr_bank.sv
module prr_addr_bank
  import prr_pkg::*;
#(
  parameter int N     = 16,
  parameter int XLEN  = 32,
  parameter int IDX_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [XLEN-1:0]    wr_data,
  input  logic [N*CFG_W-1:0] cfg_flat,
  output logic [N*XLEN-1:0]  addr_flat,
  output logic               accept_any
);

  logic [XLEN-1:0] addr_r [N];
  logic [N-1:0]    acc;

  for (genvar k = 0; k < N; k++) begin : g_ent
    logic [CFG_W-1:0] own_cfg;
    logic [CFG_W-1:0] nxt_cfg;
    logic             has_next;

    assign own_cfg = cfg_flat[k*CFG_W +: CFG_W];
    if (k < N - 1) begin : g_nxt
      assign nxt_cfg  = cfg_flat[(k+1)*CFG_W +: CFG_W];
      assign has_next = 1'b1;
    end else begin : g_last
      assign nxt_cfg  = '0;
      assign has_next = 1'b0;
    end

    assign acc[k] = wr_en && (wr_idx == IDX_W'(k)) &&
                    addr_write_ok(own_cfg, has_next, nxt_cfg);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_r[k] <= '0;
      else if (acc[k]) addr_r[k] <= wr_data;
    end

    assign addr_flat[k*XLEN +: XLEN] = addr_r[k];

    AST_ADDR_SELF_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      own_cfg[BIT_L] |=> (addr_r[k] == $past(addr_r[k]))); // R7

    AST_ADDR_TOR_NEIGHBOUR: assert property (@(posedge clk) disable iff (!rst_n)
      (has_next && nxt_cfg[BIT_L] && nxt_cfg[4:3] == 2'd1)
        |=> (addr_r[k] == $past(addr_r[k]))); // R8
  end

  assign accept_any = |acc;

endmodule

// File: rtl/prr_sec_reg.sv
module prr_sec_reg
  import prr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEC_W-1:0] wr_data,
  input  logic             any_locked,
  output logic             sec_lockdown,
  output logic             sec_whitelist,
  output logic             sec_bypass
);

  logic [SEC_W-1:0] sec_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sec_r <= '0;
    else if (wr_en) sec_r <= sec_update(sec_r, wr_data, any_locked);
  end

  assign sec_lockdown  = sec_r[SEC_LOCKDOWN];
  assign sec_whitelist = sec_r[SEC_WHITELIST];
  assign sec_bypass    = sec_r[SEC_BYPASS];

  AST_LOCKDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sec_lockdown |=> sec_lockdown); // R9
  AST_WHITELIST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sec_whitelist |=> sec_whitelist); // R9
  AST_BYPASS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_bypass && any_locked) |=> !sec_bypass); // R10

endmodule

// File: rtl/prot_region_regs.sv
module prot_region_regs
  import prr_pkg::*;
#(
  parameter int N     = 16,
  parameter int XLEN  = 32,
  parameter int IDX_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enhanced_en,
  input  logic [1:0]          csr_sel,
  input  logic [IDX_W-1:0]    csr_idx,
  input  logic [XLEN-1:0]     csr_wdata,
  input  logic                csr_we,
  output logic [XLEN-1:0]     csr_rdata,
  output logic [N*CFG_W-1:0]  cfg_flat,
  output logic [N*XLEN-1:0]   addr_flat,
  output logic                sec_lockdown,
  output logic                sec_whitelist,
  output logic                sec_bypass,
  output logic                cfg_changed
);

  localparam int BYTES = XLEN / CFG_W;

  csr_sel_e sel;
  logic     cfg_wr, addr_wr, sec_wr;
  logic     cfg_acc, addr_acc, any_locked;

  assign sel     = csr_sel_e'(csr_sel);
  assign cfg_wr  = csr_we && (sel == SEL_CFG);
  assign addr_wr = csr_we && (sel == SEL_ADDR);
  assign sec_wr  = csr_we && (sel == SEL_SEC);

  prr_cfg_bank #(.N(N), .XLEN(XLEN), .IDX_W(IDX_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_wr),
    .wr_idx       (csr_idx),
    .wr_data      (csr_wdata),
    .enhanced_en  (enhanced_en),
    .sec_bypass   (sec_bypass),
    .sec_lockdown (sec_lockdown),
    .cfg_flat     (cfg_flat),
    .accept_any   (cfg_acc),
    .any_locked   (any_locked)
  );

  prr_addr_bank #(.N(N), .XLEN(XLEN), .IDX_W(IDX_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (addr_wr),
    .wr_idx     (csr_idx),
    .wr_data    (csr_wdata),
    .cfg_flat   (cfg_flat),
    .addr_flat  (addr_flat),
    .accept_any (addr_acc)
  );

  prr_sec_reg u_sec (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (sec_wr),
    .wr_data       (csr_wdata[SEC_W-1:0]),
    .any_locked    (any_locked),
    .sec_lockdown  (sec_lockdown),
    .sec_whitelist (sec_whitelist),
    .sec_bypass    (sec_bypass)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_changed <= 1'b0;
    else        cfg_changed <= cfg_acc | addr_acc;
  end

  always_comb begin
    csr_rdata = '0;
    unique case (sel)
      SEL_CFG: begin
        for (int k = 0; k < N; k++)
          if (csr_idx == IDX_W'(k / BYTES))
            csr_rdata[(k % BYTES)*CFG_W +: CFG_W] = cfg_flat[k*CFG_W +: CFG_W];
      end
      SEL_ADDR: begin
        for (int k = 0; k < N; k++)
          if (csr_idx == IDX_W'(k)) csr_rdata = addr_flat[k*XLEN +: XLEN];
      end
      SEL_SEC: begin
        csr_rdata[SEC_LOCKDOWN]  = sec_lockdown;
        csr_rdata[SEC_WHITELIST] = sec_whitelist;
        csr_rdata[SEC_BYPASS]    = sec_bypass;
      end
      default: csr_rdata = '0;
    endcase
  end

  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_changed |-> $past(csr_we)); // R12
  AST_PULSE_NOT_FROM_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_changed |-> $past(csr_sel) != 2'd2); // R12

endmodule

// File: tb/prot_region_regs_test.sv
module prot_region_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int NV = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enhanced_en = 1'b0;
  logic [1:0]        csr_sel = 2'd3;
  logic [5:0]        csr_idx = '0;
  logic [31:0]       csr_wdata = '0;
  logic              csr_we = 1'b0;
  logic [31:0]       csr_rdata;
  logic [N*8-1:0]    cfg_flat;
  logic [N*32-1:0]   addr_flat;
  logic              sec_lockdown, sec_whitelist, sec_bypass, cfg_changed;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_region_regs uut (
    .clk(clk), .rst_n(rst_n), .enhanced_en(enhanced_en),
    .csr_sel(csr_sel), .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_we(csr_we),
    .csr_rdata(csr_rdata), .cfg_flat(cfg_flat), .addr_flat(addr_flat),
    .sec_lockdown(sec_lockdown), .sec_whitelist(sec_whitelist),
    .sec_bypass(sec_bypass), .cfg_changed(cfg_changed)
  );

  // {req(4), sel(2), idx(6), wdata(32), expected readback(32)}, basic mode
  localparam logic [75:0] VEC [NV] = '{
    {4'd1,  2'd0, 6'd0,  32'h1F0D0803, 32'h1F0D0803}, // R1 packing
    {4'd1,  2'd1, 6'd3,  32'h12345678, 32'h12345678}, // R1 address word
    {4'd11, 2'd1, 6'd16, 32'hDEADBEEF, 32'h00000000}, // R11 address out of range
    {4'd11, 2'd0, 6'd4,  32'hFFFFFFFF, 32'h00000000}, // R11 config out of range
    {4'd3,  2'd0, 6'd1,  32'h00008000, 32'h00008000}, // R3 lock entry 5
    {4'd3,  2'd0, 6'd1,  32'h11223344, 32'h11228044}, // R3 locked lane kept
    {4'd7,  2'd1, 6'd5,  32'hAAAA0000, 32'h00000000}, // R7 own lock
    {4'd3,  2'd0, 6'd1,  32'h88220044, 32'h88228044}, // R3 entry 7 locked TOR
    {4'd8,  2'd1, 6'd6,  32'h00005555, 32'h00000000}, // R8 TOR neighbour blocks
    {4'd8,  2'd1, 6'd4,  32'h00000044, 32'h00000044}, // R8 mode-0 neighbour does not
    {4'd8,  2'd1, 6'd15, 32'hCAFEF00D, 32'hCAFEF00D}, // R8 last entry
    {4'd3,  2'd0, 6'd3,  32'h88000000, 32'h88000000}, // R3 lock entry 15 TOR
    {4'd7,  2'd1, 6'd15, 32'h00000001, 32'hCAFEF00D}, // R7 last entry locked
    {4'd8,  2'd1, 6'd14, 32'h00000077, 32'h00000000}, // R8 neighbour 15
    {4'd3,  2'd0, 6'd3,  32'h00000000, 32'h88000000}, // R3 unlock attempt
    {4'd10, 2'd2, 6'd0,  32'h00000007, 32'h00000003}, // R10 bypass refused
    {4'd9,  2'd2, 6'd0,  32'h00000000, 32'h00000003}, // R9 sticky flags
    {4'd11, 2'd3, 6'd0,  32'hFFFFFFFF, 32'h00000000}  // R11 select 3
  };

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(logic [1:0] s, logic [5:0] i, logic [31:0] d);
    @(negedge clk);
    csr_sel = s; csr_idx = i; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic read_check(string req, logic [1:0] s, logic [5:0] i, logic [31:0] exp);
    csr_sel = s; csr_idx = i;
    #1;
    check(req, $sformatf("read sel %0d idx %0d", s, i), csr_rdata, exp);
  endtask

  task automatic write_read(string req, logic [1:0] s, logic [5:0] i,
                            logic [31:0] d, logic [31:0] exp);
    do_write(s, i, d);
    read_check(req, s, i, exp);
  endtask

  task automatic reset_check();
    for (int i = 0; i < 5; i++) read_check("R2", 2'd0, 6'(i), 32'h0);
    read_check("R2", 2'd1, 6'd0, 32'h0);
    read_check("R2", 2'd2, 6'd0, 32'h0);
    check("R2", "cfg_flat or", {31'b0, |cfg_flat}, 32'h0);
    check("R2", "addr_flat or", {31'b0, |addr_flat}, 32'h0);
    check("R2", "pulse", {31'b0, cfg_changed}, 32'h0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check();

    // table walk, basic mode
    for (int v = 0; v < NV; v++) begin
      write_read($sformatf("R%0d", VEC[v][75:72]), VEC[v][71:70], VEC[v][69:64],
                 VEC[v][63:32], VEC[v][31:0]);
    end

    // R1 flat outputs
    check("R1", "cfg_flat entry 7", {24'b0, cfg_flat[63:56]}, 32'h88);
    check("R1", "cfg_flat entry 5", {24'b0, cfg_flat[47:40]}, 32'h80);
    check("R1", "addr_flat entry 15", addr_flat[15*32 +: 32], 32'hCAFEF00D);
    check("R9", "flag outputs", {29'b0, sec_bypass, sec_whitelist, sec_lockdown}, 32'h3);

    // R12 pulse
    do_write(2'd1, 6'd2, 32'h10);
    check("R12", "pulse after accepted address", {31'b0, cfg_changed}, 32'h1);
    @(negedge clk);
    check("R12", "pulse single cycle", {31'b0, cfg_changed}, 32'h0);
    do_write(2'd1, 6'd15, 32'h5);
    check("R12", "no pulse rejected address", {31'b0, cfg_changed}, 32'h0);
    do_write(2'd2, 6'd0, 32'h3);
    check("R12", "no pulse security write", {31'b0, cfg_changed}, 32'h0);
    do_write(2'd0, 6'd7, 32'h1);
    check("R12", "no pulse out of range", {31'b0, cfg_changed}, 32'h0);

    // mid-run reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    reset_check();

    // enhanced mode
    enhanced_en = 1'b1;
    write_read("R10", 2'd2, 6'd0, 32'h4, 32'h4);               // bypass allowed, no locks
    write_read("R4",  2'd0, 6'd0, 32'h80808080, 32'h80808080);
    write_read("R4",  2'd0, 6'd0, 32'h01020304, 32'h01020304); // locked yet taken
    write_read("R4",  2'd0, 6'd0, 32'h00000080, 32'h00000080);
    write_read("R10", 2'd2, 6'd0, 32'h0, 32'h0);               // clear allowed
    write_read("R10", 2'd2, 6'd0, 32'h4, 32'h0);               // set refused
    write_read("R6",  2'd0, 6'd0, 32'h0, 32'h00000080);
    write_read("R9",  2'd2, 6'd0, 32'h1, 32'h1);
    do_write(2'd0, 6'd1, 32'h07068384);
    check("R12", "pulse partial accept", {31'b0, cfg_changed}, 32'h1);
    read_check("R5", 2'd0, 6'd1, 32'h07008300);
    write_read("R5",  2'd0, 6'd1, 32'h00008100, 32'h00008100); // own lock ignored
    write_read("R5",  2'd0, 6'd0, 32'h0, 32'h0);
    write_read("R9",  2'd2, 6'd0, 32'h0, 32'h1);

    done = 1;
    finish_run();
  end

endmodule